// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one cache line after a miss. On accepting a miss it sends memory a single burst request that starts at the word the processor asked for. The first word that comes back is handed to the processor with a one-cycle restart strobe, so execution can resume while the rest of the line is still arriving. The remaining beats arrive in wrap-around order: the requested word, then the following words, wrapping past the end of the line back to word zero. Each beat is written into the cache data array through a registered write port.

While the fill is in progress, the block tracks which words of the line have already been written. A processor access to the line being filled stalls only if it targets a word that has not yet been written. Accesses to any other line never stall. The line is reported complete, which lets the surrounding cache set its valid bit, only together with the write of the final word. A new miss is not taken until the current fill has finished. Tag lookup and victim selection belong to the surrounding cache.

Top module: `cwf_line_fill`

## Requirements
- R1: `miss_ready` is 1 when no fill is in progress. A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. `miss_ready` is 0 from the next cycle until the fill finishes, and `miss_valid` has no effect while it is 0.
- R2: In the cycle after acceptance, `mem_req_valid` is 1 for exactly one cycle. It carries the missed line on `mem_req_line` and the missed word offset on `mem_req_word`.
- R3: Beat k (counting from 0) of `mem_rsp_valid` during a fill is written one cycle later: `cw_en`=1, `cw_line` = the fill line, `cw_word` = (offset + k) mod WORDS, and `cw_data` = the beat data.
- R4: In the cycle after the first beat of a fill, `cpu_restart` is 1 and `cpu_rdata` holds that beat's data. `cpu_restart` pulses exactly once per fill.
- R5: `fill_done` is 1 only in the cycle that carries the write of beat WORDS-1. `miss_ready` returns to 1 in that same cycle.
- R6: `cpu_stall` is 1 exactly when all of the following hold: `cpu_acc_valid` is 1, a fill of `cpu_acc_line` has been accepted and its `fill_done` cycle has not yet passed, and word `cpu_acc_word` has not been presented on the write port in an earlier cycle of that fill.
- R7: `mem_rsp_valid` outside a fill produces no write, no restart and no completion.
- R8: After reset: `miss_ready`=1, and `mem_req_valid`, `cw_en`, `cpu_restart`, `fill_done` and `cpu_stall` are all 0.
- R9: The wrap works from every starting offset, including WORDS-1, whose next word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | OFF_W | Word offset within the line that missed |
| miss_ready | output | 1 | Controller idle and able to accept a miss |
| mem_req_valid | output | 1 | One-cycle burst request to memory |
| mem_req_line | output | LINE_AW | Line to fetch |
| mem_req_word | output | OFF_W | First (critical) word of the burst |
| mem_rsp_valid | input | 1 | Memory beat present |
| mem_rsp_data | input | DATA_W | Memory beat data |
| cpu_rdata | output | DATA_W | Critical word for the processor |
| cpu_restart | output | 1 | One-cycle strobe: processor may resume |
| cpu_acc_valid | input | 1 | Processor access probe |
| cpu_acc_line | input | LINE_AW | Line of the probe |
| cpu_acc_word | input | OFF_W | Word of the probe |
| cpu_stall | output | 1 | Probe must wait for its word |
| cw_en | output | 1 | Cache data write enable |
| cw_line | output | LINE_AW | Cache write line |
| cw_word | output | OFF_W | Cache write word |
| cw_data | output | DATA_W | Cache write data |
| fill_done | output | 1 | Last word written; line may be marked valid |

## Verification
The bench builds the block with WORDS=4, DATA_W=64 and LINE_AW=8. That is a line of four 8-byte words, delivered one 64-bit beat at a time. With a four-word line, fills can be started from each of the four offsets in a short run, so every wrap point, including the jump from word 3 to word 0, is reached. Beats arrive both back to back and with idle gaps. Processor probes target the line being filled, its words before and after they arrive, and an unrelated line. A miss request held high through a fill shows that it is accepted only once the controller is ready again.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_st_t;
endpackage

// File: rtl/cwf_wrap_seq.sv
// Beat sequencer: walks the line from the critical word, wrapping at the end.
module cwf_wrap_seq #(
  parameter  int WORDS = 4,
  localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] start_word,
  input  logic             adv,
  output logic [OFF_W-1:0] cur_word,
  output logic             is_first,
  output logic             is_last
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] ptr;
  logic [OFF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      cnt <= '0;
    end else if (load) begin
      ptr <= start_word;
      cnt <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  assign cur_word = ptr;
  assign is_first = (cnt == '0);
  assign is_last  = (cnt == LAST);
endmodule

// File: rtl/cwf_arrival_map.sv
// Records which words of the pending line are already in the array.
module cwf_arrival_map #(
  parameter  int WORDS   = 4,
  parameter  int LINE_AW = 8,
  localparam int OFF_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm,
  input  logic [LINE_AW-1:0] arm_line,
  input  logic               mark_en,
  input  logic [OFF_W-1:0]   mark_word,
  input  logic               close,
  input  logic               acc_valid,
  input  logic [LINE_AW-1:0] acc_line,
  input  logic [OFF_W-1:0]   acc_word,
  output logic               stall
);
  logic               pend;
  logic [LINE_AW-1:0] line_q;
  logic [WORDS-1:0]   have;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      line_q <= '0;
      have   <= '0;
    end else begin
      if (close)   pend <= 1'b0;
      if (mark_en) have[mark_word] <= 1'b1;
      // a new fill overrides the closing of the previous one
      if (arm) begin
        pend   <= 1'b1;
        line_q <= arm_line;
        have   <= '0;
      end
    end
  end

  assign stall = acc_valid && pend && (acc_line == line_q) && !have[acc_word];
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter  int WORDS   = 4,
  parameter  int DATA_W  = 64,
  parameter  int LINE_AW = 8,
  localparam int OFF_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OFF_W-1:0]   miss_word,
  output logic               miss_ready,
  output logic               mem_req_valid,
  output logic [LINE_AW-1:0] mem_req_line,
  output logic [OFF_W-1:0]   mem_req_word,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_restart,
  input  logic               cpu_acc_valid,
  input  logic [LINE_AW-1:0] cpu_acc_line,
  input  logic [OFF_W-1:0]   cpu_acc_word,
  output logic               cpu_stall,
  output logic               cw_en,
  output logic [LINE_AW-1:0] cw_line,
  output logic [OFF_W-1:0]   cw_word,
  output logic [DATA_W-1:0]  cw_data,
  output logic               fill_done
);
  fill_st_t           st;
  logic [LINE_AW-1:0] fill_line;
  logic               accept;
  logic               beat;
  logic [OFF_W-1:0]   cur_word;
  logic               is_first;
  logic               is_last;

  assign accept = miss_ready && miss_valid;
  assign beat   = (st == ST_FILL) && mem_rsp_valid;

  cwf_wrap_seq #(.WORDS(WORDS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .start_word (miss_word),
    .adv        (beat),
    .cur_word   (cur_word),
    .is_first   (is_first),
    .is_last    (is_last)
  );

  cwf_arrival_map #(.WORDS(WORDS), .LINE_AW(LINE_AW)) u_map (
    .clk       (clk),
    .rst       (rst),
    .arm       (accept),
    .arm_line  (miss_line),
    .mark_en   (cw_en),
    .mark_word (cw_word),
    .close     (fill_done),
    .acc_valid (cpu_acc_valid),
    .acc_line  (cpu_acc_line),
    .acc_word  (cpu_acc_word),
    .stall     (cpu_stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      miss_ready    <= 1'b1;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      mem_req_word  <= '0;
      fill_line     <= '0;
      cw_en         <= 1'b0;
      cw_line       <= '0;
      cw_word       <= '0;
      cw_data       <= '0;
      cpu_rdata     <= '0;
      cpu_restart   <= 1'b0;
      fill_done     <= 1'b0;
    end else begin
      mem_req_valid <= 1'b0;
      cw_en         <= 1'b0;
      cpu_restart   <= 1'b0;
      fill_done     <= 1'b0;
      if (accept) begin
        st            <= ST_FILL;
        miss_ready    <= 1'b0;
        mem_req_valid <= 1'b1;
        mem_req_line  <= miss_line;
        mem_req_word  <= miss_word;
        fill_line     <= miss_line;
      end
      if (beat) begin
        cw_en   <= 1'b1;
        cw_line <= fill_line;
        cw_word <= cur_word;
        cw_data <= mem_rsp_data;
        if (is_first) begin
          cpu_rdata   <= mem_rsp_data;
          cpu_restart <= 1'b1;
        end
        if (is_last) begin
          fill_done  <= 1'b1;
          st         <= ST_IDLE;
          miss_ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk (
  input logic clk,
  input logic rst,
  input logic miss_valid,
  input logic miss_ready,
  input logic mem_req_valid,
  input logic mem_rsp_valid,
  input logic cpu_restart,
  input logic cw_en,
  input logic fill_done,
  input logic cpu_stall,
  input logic cpu_acc_valid
);
  logic restarted;

  always_ff @(posedge clk) begin
    if (rst)                restarted <= 1'b0;
    else if (mem_req_valid) restarted <= 1'b0;
    else if (cpu_restart)   restarted <= 1'b1;
  end

  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);

  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_write_after_beat_r3: assert property (@(posedge clk) disable iff (rst)
    cw_en |-> $past(mem_rsp_valid));

  p_one_restart_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_restart |-> !restarted);

  p_done_with_write_r5: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> (cw_en && miss_ready));

  p_stall_needs_probe_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> cpu_acc_valid);
endmodule

bind cwf_line_fill cwf_line_fill_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .cpu_restart   (cpu_restart),
  .cw_en         (cw_en),
  .fill_done     (fill_done),
  .cpu_stall     (cpu_stall),
  .cpu_acc_valid (cpu_acc_valid)
);

// File: tb/cwf_line_fill_tb.sv
`timescale 1ns/100ps
module cwf_line_fill_tb;
  localparam int W  = 4;
  localparam int DW = 64;
  localparam int LA = 8;
  localparam int OW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [LA-1:0] miss_line = '0;
  logic [OW-1:0] miss_word = '0;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          cpu_acc_valid = 1'b0;
  logic [LA-1:0] cpu_acc_line = '0;
  logic [OW-1:0] cpu_acc_word = '0;
  logic          miss_ready, mem_req_valid, cpu_restart, cpu_stall, cw_en, fill_done;
  logic [LA-1:0] mem_req_line, cw_line;
  logic [OW-1:0] mem_req_word, cw_word;
  logic [DW-1:0] cpu_rdata, cw_data;

  int checks = 0;
  int bad    = 0;

  always #2.5 clk = ~clk;

  cwf_line_fill #(.WORDS(W), .DATA_W(DW), .LINE_AW(LA)) u_dut (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_req_word(mem_req_word),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cpu_rdata(cpu_rdata), .cpu_restart(cpu_restart),
    .cpu_acc_valid(cpu_acc_valid), .cpu_acc_line(cpu_acc_line), .cpu_acc_word(cpu_acc_word),
    .cpu_stall(cpu_stall),
    .cw_en(cw_en), .cw_line(cw_line), .cw_word(cw_word), .cw_data(cw_data),
    .fill_done(fill_done)
  );

  // behavioural reference model
  bit      started = 0;
  bit      m_busy, m_pend;
  int      m_cnt, m_start, m_line;
  bit      m_have [W];
  bit      e_ready, e_req, e_cw, e_restart, e_done;
  int      e_req_line, e_req_word, e_cw_line, e_cw_word;
  longint  e_cw_data, e_rdata;
  int      beat_q [$];

  always @(posedge clk) begin
    bit o_cw, o_done;
    int o_word;
    started = 1;
    if (rst) begin
      m_busy = 0; m_pend = 0; m_cnt = 0; m_start = 0; m_line = 0;
      foreach (m_have[i]) m_have[i] = 0;
      e_ready = 1; e_req = 0; e_cw = 0; e_restart = 0; e_done = 0;
      e_req_line = 0; e_req_word = 0; e_cw_line = 0; e_cw_word = 0;
      e_cw_data = 0; e_rdata = 0;
    end else begin
      o_cw = e_cw; o_word = e_cw_word; o_done = e_done;
      if (o_cw) m_have[o_word] = 1;
      if (o_done) m_pend = 0;
      e_req = 0; e_cw = 0; e_restart = 0; e_done = 0;
      if (!m_busy && miss_valid) begin
        m_busy = 1; m_pend = 1; m_cnt = 0;
        m_start = int'(miss_word); m_line = int'(miss_line);
        foreach (m_have[i]) m_have[i] = 0;
        e_req = 1; e_ready = 0; e_req_line = m_line; e_req_word = m_start;
      end else if (m_busy && mem_rsp_valid) begin
        beat_q.push_back((m_start + m_cnt) % W);
        e_cw = 1; e_cw_line = m_line; e_cw_word = beat_q.pop_front();
        e_cw_data = longint'(mem_rsp_data);
        if (m_cnt == 0) begin e_restart = 1; e_rdata = longint'(mem_rsp_data); end
        if (m_cnt == W - 1) begin e_done = 1; m_busy = 0; e_ready = 1; end
        m_cnt++;
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_stall;
    if (started) begin
      e_stall = cpu_acc_valid && m_pend && (int'(cpu_acc_line) == m_line) && !m_have[cpu_acc_word];
      chk(miss_ready == e_ready, "R1 miss_ready", miss_ready, e_ready);
      chk(mem_req_valid == e_req, "R2 mem_req_valid", mem_req_valid, e_req);
      if (e_req) begin
        chk(int'(mem_req_line) == e_req_line, "R2 mem_req_line", mem_req_line, e_req_line);
        chk(int'(mem_req_word) == e_req_word, "R2 mem_req_word", mem_req_word, e_req_word);
      end
      chk(cw_en == e_cw, "R3 cw_en", cw_en, e_cw);
      if (e_cw) begin
        chk(int'(cw_line) == e_cw_line, "R3 cw_line", cw_line, e_cw_line);
        chk(int'(cw_word) == e_cw_word, "R3 cw_word", cw_word, e_cw_word);
        chk(longint'(cw_data) == e_cw_data, "R3 cw_data", cw_data, e_cw_data);
      end
      chk(cpu_restart == e_restart, "R4 cpu_restart", cpu_restart, e_restart);
      if (e_restart)
        chk(longint'(cpu_rdata) == e_rdata, "R4 cpu_rdata", cpu_rdata, e_rdata);
      chk(fill_done == e_done, "R5 fill_done", fill_done, e_done);
      chk(cpu_stall == e_stall, "R6 cpu_stall", cpu_stall, e_stall);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_fill(int line, int start, int gap_mod, bit hold_miss);
    miss_valid = 1; miss_line = LA'(line); miss_word = OW'(start);
    tick();
    if (hold_miss) miss_line = LA'(line + 1);
    else miss_valid = 0;
    tick();
    for (int k = 0; k < W; k++) begin
      if (gap_mod != 0 && (k % gap_mod) == 1) begin
        mem_rsp_valid = 0;
        tick();
      end
      mem_rsp_valid = 1;
      mem_rsp_data  = {8'hC3, 8'(line), 8'(start), 8'(k), 32'h5A5A_0000 + 32'(k * 17)};
      cpu_acc_valid = 1;
      cpu_acc_line  = (k == 2) ? LA'(line + 7) : LA'(line);
      cpu_acc_word  = OW'((start + k + 1) % W);
      tick();
      // R9: written word follows the wrap from the critical word
      chk(int'(cw_word) == (start + k) % W, "R9 wrap word", cw_word, (start + k) % W);
    end
    mem_rsp_valid = 0; miss_valid = 0;
    cpu_acc_line = LA'(line); cpu_acc_word = OW'(start);
    tick();
    cpu_acc_valid = 0;
    tick();
  endtask

  initial begin
    cpu_acc_valid = 1;
    repeat (3) tick();
    // R8: reset state
    chk(miss_ready == 1'b1, "R8 ready in reset", miss_ready, 1);
    chk({mem_req_valid, cw_en, cpu_restart, fill_done, cpu_stall} == 5'b0,
        "R8 pulses in reset", {mem_req_valid, cw_en, cpu_restart, fill_done, cpu_stall}, 0);
    rst = 0; cpu_acc_valid = 0;
    tick();
    // R7: stray beats while idle
    mem_rsp_valid = 1; mem_rsp_data = 64'hDEAD_BEEF_0000_0001;
    tick(); tick();
    chk(cw_en == 1'b0 && cpu_restart == 1'b0 && fill_done == 1'b0, "R7 idle beat ignored",
        {cw_en, cpu_restart, fill_done}, 0);
    mem_rsp_valid = 0;
    tick();
    run_fill(5, 2, 0, 0);
    run_fill(9, 3, 2, 1);
    run_fill(9, 3, 0, 0);
    for (int s = 0; s < W; s++) run_fill(20 + s, s, s, 0);
    run_fill(200, 1, 3, 1);
    repeat (4) tick();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule